// File: doc/BRIEF.md
# Panel-Aware Two-Pin GPIO Register

This block holds the data and direction bits of two general-purpose pins, together with two small mode fields that say whether the second pin has been lent to a display panel. In plain GPIO mode each pin drives its stored bit when set as an output. When a pin is set as an input, reading its data bit returns the level seen on the pin.

When one of four panel modes is active, the stored bit for pin 1 no longer drives the pin directly. It becomes a gate on a panel control signal that another block generates. A 1 lets the selected signal through to pin 1, and a 0 holds the pin low. Pin 1 is always driven in these modes. Writes to the pin 0 data bit are dropped while any panel mode is active. Pin 0 keeps its plain GPIO behaviour for reading and driving.

A primary mode field picks one of two panel signals and takes priority. A secondary field picks one of two others, and it is used only when the primary field selects neither. Software reaches all four registers through a simple single-cycle write port and a combinational read port.

Top module: `panelGpioReg`

## Requirements
- R1: Register map by `addr`: 0 = pin data (bit 1 = pin 1, bit 0 = pin 0), 1 = direction (1 = output), 2 = primary mode field in bits 1:0, 3 = secondary mode field in bits 1:0. A write with `wrEn` high is stored at the next rising clock edge and not before. In plain mode, a pin whose direction bit is 1 drives its stored data bit with its output enable high.
- R2: In plain mode, reading address 0 returns the pin level for each pin set as input, and the stored bit for each pin set as output. Address 1 reads back the direction bits, and addresses 2 and 3 read back the mode fields. Unused upper bits read 0.
- R3: Primary field 2'b11 selects raw signal bit 0 (vertical shift clock). Pin 1 then outputs that signal ANDed with data bit 1, so a 0 in data bit 1 forces the pin low.
- R4: Primary field 2'b10 selects raw signal bit 1 (line latch strobe) with the same gating.
- R5: When the primary field is 2'b00 or 2'b01, secondary field 2'b01 selects raw signal bit 2 (polarity signal) and 2'b10 selects raw signal bit 3 (output-enable signal), both with the same gating.
- R6: When the primary field is 2'b11 or 2'b10, the secondary field has no effect on pin 1.
- R7: In any panel mode, pin 1's output enable is 1 whatever its direction bit.
- R8: In any panel mode, a write to address 0 leaves stored data bit 0 unchanged, while data bit 1 still updates.
- R9: When the primary field is 2'b00 or 2'b01 and the secondary field is 2'b00 or 2'b11, both pins are in plain mode.
- R10: In a panel mode, reading bit 1 of address 0 returns the stored gate value, not the pin level.
- R11: A synchronous reset clears both data bits, sets both pins to input and clears both mode fields. Afterwards all outputs and output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| pinIn | input | 2 | Levels seen on the two pins |
| rawSig | input | 4 | Panel control signals: 0 vshift clock, 1 latch strobe, 2 polarity, 3 output enable |
| pinOut | output | 2 | Pin output values |
| pinOe | output | 2 | Pin output enables |

## Verification
The assertions assume that `wrEn` and `addr` are held steady across each rising edge and are never unknown outside reset. They also assume that one register is written per cycle, so a mode change and a data write never fall on the same edge. The bench changes every input only on the falling clock edge and issues one write per cycle through a single task. Because the raw panel signals are sampled purely combinationally, the bench sets them and samples the pin outputs in the low half of the clock, well clear of any edge.

// File: rtl/panelGpioPkg.sv
package panelGpioPkg;

  typedef enum logic [2:0] {
    MODE_GPIO    = 3'd0,
    MODE_VSHIFT  = 3'd1,
    MODE_LSTROBE = 3'd2,
    MODE_POLAR   = 3'd3,
    MODE_DRVEN   = 3'd4
  } panelMode_e;

  localparam logic [1:0] PRI_VSHIFT  = 2'b11;
  localparam logic [1:0] PRI_LSTROBE = 2'b10;
  localparam logic [1:0] SEC_POLAR   = 2'b01;
  localparam logic [1:0] SEC_DRVEN   = 2'b10;

  localparam int RAW_W = 4;
  localparam int PIN_N = 2;
  localparam int FIELD_W = 2;

  typedef struct packed {
    logic       ldData1;
    logic       ldData0;
    logic       ldDir;
    logic       ldModeA;
    logic       ldModeB;
    logic       panelOn;
    logic [1:0] sigSel;
  } ctrlStrobe_t;

  function automatic panelMode_e resolveMode(input logic [1:0] priField,
                                             input logic [1:0] secField);
    panelMode_e m;
    if (priField == PRI_VSHIFT)       m = MODE_VSHIFT;
    else if (priField == PRI_LSTROBE) m = MODE_LSTROBE;
    else if (secField == SEC_POLAR)   m = MODE_POLAR;
    else if (secField == SEC_DRVEN)   m = MODE_DRVEN;
    else                              m = MODE_GPIO;
    return m;
  endfunction

endpackage

// File: rtl/panelGpioCtrl.sv
module panelGpioCtrl
  import panelGpioPkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int ADDR_DATA = 0,
  parameter int ADDR_DIR  = 1,
  parameter int ADDR_PRI  = 2,
  parameter int ADDR_SEC  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [FIELD_W-1:0]  modeA,
  input  logic [FIELD_W-1:0]  modeB,
  output ctrlStrobe_t         strobe,
  output panelMode_e          mode
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_PRI  = ADDR_W'(ADDR_PRI);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADDR_SEC);

  logic hitData, hitDir, hitPri, hitSec;
  logic panelOn;

  always_comb begin
    hitData = wrEn && (addr == A_DATA);
    hitDir  = wrEn && (addr == A_DIR);
    hitPri  = wrEn && (addr == A_PRI);
    hitSec  = wrEn && (addr == A_SEC);
  end

  always_comb begin
    mode    = resolveMode(modeA, modeB);
    panelOn = (mode != MODE_GPIO);
  end

  always_comb begin
    strobe         = '0;
    strobe.ldData1 = hitData;
    strobe.ldData0 = hitData && !panelOn;
    strobe.ldDir   = hitDir;
    strobe.ldModeA = hitPri;
    strobe.ldModeB = hitSec;
    strobe.panelOn = panelOn;
    unique case (mode)
      MODE_VSHIFT:  strobe.sigSel = 2'd0;
      MODE_LSTROBE: strobe.sigSel = 2'd1;
      MODE_POLAR:   strobe.sigSel = 2'd2;
      MODE_DRVEN:   strobe.sigSel = 2'd3;
      default:      strobe.sigSel = 2'd0;
    endcase
  end

  // R6: a primary selection always wins and routes one of the two primary signals
  a_r6_primary_wins: assert property (@(posedge clk) disable iff (rst)
    (modeA[1]) |-> (strobe.panelOn && (strobe.sigSel[1] == 1'b0)));

  // R9: the two idle secondary codes with an idle primary field leave plain mode
  a_r9_plain_codes: assert property (@(posedge clk) disable iff (rst)
    (!modeA[1] && (modeB[1] == modeB[0])) |-> !strobe.panelOn);

  // R8: no pin 0 load strobe can be raised while a panel mode is active
  a_r8_no_bit0_load: assert property (@(posedge clk) disable iff (rst)
    strobe.panelOn |-> !strobe.ldData0);

endmodule

// File: rtl/panelGpioData.sv
module panelGpioData
  import panelGpioPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int ADDR_DATA = 0,
  parameter int ADDR_DIR  = 1,
  parameter int ADDR_PRI  = 2,
  parameter int ADDR_SEC  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [PIN_N-1:0]    pinIn,
  input  logic [RAW_W-1:0]    rawSig,
  output logic [DATA_W-1:0]   rdData,
  output logic [PIN_N-1:0]    pinOut,
  output logic [PIN_N-1:0]    pinOe,
  output logic [FIELD_W-1:0]  modeA,
  output logic [FIELD_W-1:0]  modeB,
  output logic                gate1
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_PRI  = ADDR_W'(ADDR_PRI);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(ADDR_SEC);

  logic [PIN_N-1:0]   dataReg;
  logic [PIN_N-1:0]   dirReg;
  logic [FIELD_W-1:0] priReg;
  logic [FIELD_W-1:0] secReg;
  logic               rawPick;
  logic [PIN_N-1:0]   dataView;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
      dirReg  <= '0;
      priReg  <= '0;
      secReg  <= '0;
    end else begin
      if (strobe.ldData1) dataReg[1] <= wrData[1];
      if (strobe.ldData0) dataReg[0] <= wrData[0];
      if (strobe.ldDir)   dirReg     <= wrData[PIN_N-1:0];
      if (strobe.ldModeA) priReg     <= wrData[FIELD_W-1:0];
      if (strobe.ldModeB) secReg     <= wrData[FIELD_W-1:0];
    end
  end

  assign modeA = priReg;
  assign modeB = secReg;
  assign gate1 = dataReg[1];
  assign rawPick = rawSig[strobe.sigSel];

  // Pin 0 is never lent to the panel; pin 1 is muxed by panel mode
  always_comb begin
    pinOut[0] = dataReg[0];
    pinOe[0]  = dirReg[0];
    if (strobe.panelOn) begin
      pinOut[1] = dataReg[1] & rawPick;
      pinOe[1]  = 1'b1;
    end else begin
      pinOut[1] = dataReg[1];
      pinOe[1]  = dirReg[1];
    end
  end

  for (genvar i = 0; i < PIN_N; i++) begin : g_view
    if (i == 1) begin : g_shared
      assign dataView[i] = (strobe.panelOn || dirReg[i]) ? dataReg[i] : pinIn[i];
    end else begin : g_plain
      assign dataView[i] = dirReg[i] ? dataReg[i] : pinIn[i];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_DATA:  rdData[PIN_N-1:0]   = dataView;
      A_DIR:   rdData[PIN_N-1:0]   = dirReg;
      A_PRI:   rdData[FIELD_W-1:0] = priReg;
      A_SEC:   rdData[FIELD_W-1:0] = secReg;
      default: rdData = '0;
    endcase
  end

  // R1: a data load on one edge shows the written gate bit after it
  a_r1_gate_load: assert property (@(posedge clk) disable iff (rst)
    strobe.ldData1 |=> (dataReg[1] == $past(wrData[1])));

  // R8: without a pin 0 load the stored pin 0 bit holds
  a_r8_bit0_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.ldData0 |=> $stable(dataReg[0]));

endmodule

// File: rtl/panelGpioReg.sv
module panelGpioReg
  import panelGpioPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [1:0]        pinIn,
  input  logic [3:0]        rawSig,
  output logic [1:0]        pinOut,
  output logic [1:0]        pinOe
);

  localparam int ADDR_DATA = 0;
  localparam int ADDR_DIR  = 1;
  localparam int ADDR_PRI  = 2;
  localparam int ADDR_SEC  = 3;

  ctrlStrobe_t        strobe;
  panelMode_e         mode;
  logic [FIELD_W-1:0] modeA;
  logic [FIELD_W-1:0] modeB;
  logic               gate1;

  panelGpioCtrl #(
    .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR),
    .ADDR_PRI(ADDR_PRI), .ADDR_SEC(ADDR_SEC)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr),
    .modeA(modeA), .modeB(modeB), .strobe(strobe), .mode(mode)
  );

  panelGpioData #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_DATA(ADDR_DATA), .ADDR_DIR(ADDR_DIR),
    .ADDR_PRI(ADDR_PRI), .ADDR_SEC(ADDR_SEC)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .addr(addr), .wrData(wrData),
    .pinIn(pinIn), .rawSig(rawSig), .rdData(rdData), .pinOut(pinOut),
    .pinOe(pinOe), .modeA(modeA), .modeB(modeB), .gate1(gate1)
  );

  // R7: any panel mode drives pin 1
  a_r7_oe_forced: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_GPIO) |-> pinOe[1]);

  // R3: a cleared gate holds pin 1 low in a panel mode
  a_r3_force_low: assert property (@(posedge clk) disable iff (rst)
    ((mode != MODE_GPIO) && !gate1) |-> !pinOut[1]);

  // R8: a data write during a panel mode leaves pin 0 alone
  a_r8_pin0_stable: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (addr == ADDR_W'(ADDR_DATA)) && (mode != MODE_GPIO)) |=> $stable(pinOut[0]));

  // R11: after a reset edge nothing is driven
  a_r11_reset_idle: assert property (@(posedge clk)
    rst |=> ((pinOe == 2'b00) && (pinOut == 2'b00)));

endmodule

// File: tb/sim_panelGpioReg.sv
module sim_panelGpioReg;

  logic       clk = 1'b0;
  logic       rst;
  logic       wrEn;
  logic [1:0] addr;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic [1:0] pinIn;
  logic [3:0] rawSig;
  logic [1:0] pinOut;
  logic [1:0] pinOe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  panelGpioReg u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .rawSig(rawSig), .pinOut(pinOut), .pinOe(pinOe)
  );

  // vector: req(4) priField(2) secField(2) gate(1) raw(4) expOut(1) expOe(1)
  typedef struct packed {
    logic [3:0] req;
    logic [1:0] pri;
    logic [1:0] sec;
    logic       gate;
    logic [3:0] raw;
    logic       expOut;
    logic       expOe;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  2'b11, 2'b00, 1'b1, 4'b0001, 1'b1, 1'b1}, // R3 pass
    '{4'd3,  2'b11, 2'b00, 1'b0, 4'b0001, 1'b0, 1'b1}, // R3 force low
    '{4'd6,  2'b11, 2'b01, 1'b1, 4'b1110, 1'b0, 1'b1}, // R6 secondary ignored
    '{4'd4,  2'b10, 2'b00, 1'b1, 4'b0010, 1'b1, 1'b1}, // R4 pass
    '{4'd6,  2'b10, 2'b10, 1'b1, 4'b1101, 1'b0, 1'b1}, // R6 secondary ignored
    '{4'd4,  2'b10, 2'b00, 1'b0, 4'b1111, 1'b0, 1'b1}, // R4 force low
    '{4'd5,  2'b00, 2'b01, 1'b1, 4'b0100, 1'b1, 1'b1}, // R5 polarity
    '{4'd5,  2'b01, 2'b01, 1'b1, 4'b1011, 1'b0, 1'b1}, // R5 polarity low
    '{4'd5,  2'b00, 2'b10, 1'b1, 4'b1000, 1'b1, 1'b1}, // R5 drive enable
    '{4'd7,  2'b01, 2'b10, 1'b0, 4'b1111, 1'b0, 1'b1}, // R7 enable forced, gate low
    '{4'd9,  2'b00, 2'b00, 1'b1, 4'b0000, 1'b1, 1'b0}, // R9 plain, input
    '{4'd9,  2'b01, 2'b11, 1'b0, 4'b1111, 1'b0, 1'b0}, // R9 plain
    '{4'd9,  2'b00, 2'b11, 1'b1, 4'b1111, 1'b1, 1'b0}  // R9 plain
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAt(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst = 1'b1; wrEn = 1'b0; addr = 2'd0; wrData = 8'h00; pinIn = 2'b00; rawSig = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    chk({6'd0, pinOe}, 8'h00, "R11 oe after reset");
    chk({6'd0, pinOut}, 8'h00, "R11 out after reset");
    readAt(2'd2, rd); chk(rd, 8'h00, "R11 primary field");
    readAt(2'd3, rd); chk(rd, 8'h00, "R11 secondary field");

    // R1: write timing and output drive
    regWrite(2'd1, 8'h03);
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wrData = 8'h01;
    #1 chk({6'd0, pinOut}, 8'h00, "R1 not before edge");
    @(negedge clk);
    wrEn = 1'b0;
    chk({6'd0, pinOut}, 8'h01, "R1 after edge");
    chk({6'd0, pinOe}, 8'h03, "R1 oe from direction");

    // R2: readback for outputs and inputs
    pinIn = 2'b10;
    readAt(2'd0, rd); chk(rd, 8'h01, "R2 output readback");
    regWrite(2'd1, 8'h00);
    readAt(2'd0, rd); chk(rd, 8'h02, "R2 input readback");
    readAt(2'd1, rd); chk(rd, 8'h00, "R2 direction readback");

    // table walk over panel modes (R3 to R9), direction = inputs
    for (int i = 0; i < NV; i++) begin
      regWrite(2'd2, {6'd0, VECS[i].pri});
      regWrite(2'd3, {6'd0, VECS[i].sec});
      regWrite(2'd0, {6'd0, VECS[i].gate, 1'b0});
      @(negedge clk);
      rawSig = VECS[i].raw;
      #1;
      checks++;
      if (pinOut[1] !== VECS[i].expOut || pinOe[1] !== VECS[i].expOe) begin
        errors++;
        $display("FAIL R%0d vector %0d actual out %b oe %b expected out %b oe %b",
                 VECS[i].req, i, pinOut[1], pinOe[1], VECS[i].expOut, VECS[i].expOe);
      end
    end

    // R8: bit 0 write blocked in a panel mode, bit 1 still updates
    regWrite(2'd2, 8'h00);
    regWrite(2'd3, 8'h00);
    regWrite(2'd1, 8'h01);
    regWrite(2'd0, 8'h01);
    regWrite(2'd2, 8'h03);
    regWrite(2'd0, 8'h02);
    chk({7'd0, pinOut[0]}, 8'h01, "R8 pin0 held");
    pinIn = 2'b00;
    // R10: bit 1 reads stored gate, not the low pin level
    readAt(2'd0, rd); chk(rd, 8'h03, "R10 gate readback with R8 bit0");
    regWrite(2'd2, 8'h00);
    readAt(2'd0, rd); chk(rd, 8'h01, "R8 bit0 after return to plain");

    // R11: reset mid-run
    regWrite(2'd1, 8'h03);
    regWrite(2'd3, 8'h02);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk({4'd0, pinOe, pinOut}, 8'h00, "R11 reset mid-run");
    readAt(2'd3, rd); chk(rd, 8'h00, "R11 secondary cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule